// File: doc/BRIEF.md
# Variable-Length CAN Receive Record Buffer

This block holds received CAN frames in a circular byte store as packed records of uneven length. A record starts with a frame-information byte. The identifier bytes come next, then as many data bytes as the frame carries. An upstream receiver presents a frame that has already passed acceptance filtering and pulses a store strobe. The block then checks the free space. If the whole record fits, it writes the record one byte per cycle and publishes it as a single unit. If it does not fit, the block drops the frame and raises an overrun flag.

A host reads the oldest record through a 13-byte window that sits at the read start pointer. A release strobe retires that record. The length of the record is recomputed from its own header byte. A hold-in-reset input blocks new frames. When this input falls, the byte and message counts are cleared and the window is realigned to the write pointer.

The controller is a three-state machine:
- `S_IDLE`: waits for a store strobe. It moves to `S_CHECK` on a strobe taken outside reset mode.
- `S_CHECK`: compares the byte count plus the record length with the buffer size. If the record fits it moves to `S_WRITE`. Otherwise it drops the frame and returns to `S_IDLE`.
- `S_WRITE`: writes one byte per cycle. After the last byte it commits the record and returns to `S_IDLE`.

Hold-in-reset forces `S_CHECK` and `S_WRITE` back to `S_IDLE` without a commit.

Top module: `canrx_fifo`

## Requirements
- R1: The first byte of a record holds the extended flag in bit 7, the remote-request flag in bit 6, zeros in bits 5:4, and the data length code in bits 3:0. A length code above 8 is stored as 8.
- R2: An extended record has four identifier bytes after the header: id[28:21], id[20:13], id[12:5], and {id[4:0],000}. These are followed by the data bytes. The record is 5 bytes plus the length code, or 5 bytes for a remote request.
- R3: A standard record has two identifier bytes after the header: id[10:3] and {id[2:0],00000}. These are followed by the data bytes. The record is 3 bytes plus the length code, or 3 bytes for a remote request. Data byte j is taken from st_data[8j+7:8j].
- R4: Window offset k from 0 to 12 reads the buffer byte at (start + k) mod 64. Offsets 13 to 15 read 0.
- R5: A frame is dropped whole if its record length plus the bytes already held would exceed 64. A drop sets rx_overrun and irq_ovr, which stay set until rst_n. A record that fills the buffer to exactly 64 bytes is accepted.
- R6: When the last byte of a record is written, rx_status and irq_rx are set. The record becomes visible to release only after this point.
- R7: A release advances the start pointer by the record length decoded from the header at the start pointer, and removes one message.
- R8: A release while no message is held is ignored. When the message count reaches 0, rx_status and irq_rx are cleared.
- R9: While hold_reset is high, store strobes are ignored. When hold_reset falls, the byte and message counts, rx_status and irq_rx are cleared, and the start pointer is set equal to the write pointer.
- R10: rx_busy is high from the cycle after an accepted strobe until the record is stored or dropped. Store strobes that arrive while rx_busy is high are ignored.
- R11: After rst_n, all flags are 0 and every window byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_reset | input | 1 | Controller held in reset mode |
| st_valid | input | 1 | Frame store strobe |
| st_ext | input | 1 | Frame uses a 29-bit identifier |
| st_rtr | input | 1 | Frame is a remote request |
| st_dlc | input | 4 | Data length code |
| st_id | input | 29 | Identifier, right-aligned |
| st_data | input | 64 | Data bytes, byte j at bits 8j+7:8j |
| rel | input | 1 | Release the current record |
| win_addr | input | 4 | Window offset |
| win_data | output | 8 | Byte at window offset |
| rx_status | output | 1 | At least one record is held |
| rx_overrun | output | 1 | A frame was dropped for lack of space |
| rx_busy | output | 1 | A frame is being handled |
| irq_rx | output | 1 | Receive interrupt flag |
| irq_ovr | output | 1 | Overrun interrupt flag |

## Verification
The bench stores a sequence of eight frames whose total length passes 64 bytes, so the start pointer wraps partway through. A design that wrapped wrongly would return corrupted bytes in the window. Remote-request frames and a length code of 12 check that the written length and the released length stay equal; a mismatch would leave the window pointing into the middle of the next record. The overflow test fills the buffer to 52 bytes and offers a 13-byte frame, which must be dropped, and then a 12-byte frame, which must be accepted for an exact fill. A design using an off-by-one comparison fails one of these two steps. Further tests cover a release with no message held, a second strobe during busy, and leaving reset mode. Each would shift the window or leave stale flags in a design that handled it wrongly.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CHECK = 2'd1,
        S_WRITE = 2'd2
    } rx_state_t;

    localparam int unsigned ID_BITS    = 29;
    localparam int unsigned DATA_MAX   = 8;
    localparam int unsigned DATA_BITS  = 8 * DATA_MAX;
    localparam int unsigned LEN_W      = 4;

    // Record length from the fields carried in a header byte.
    function automatic logic [LEN_W-1:0] rec_len(input logic ext, input logic rtr,
                                                 input logic [3:0] dlc);
        logic [3:0] d;
        d = (dlc > 4'd8) ? 4'd8 : dlc;
        return (ext ? 4'd5 : 4'd3) + (rtr ? 4'd0 : d);
    endfunction

    function automatic logic [LEN_W-1:0] hdr_len(input logic [7:0] h);
        return rec_len(h[7], h[6], h[3:0]);
    endfunction

endpackage

// File: rtl/canrx_pack.sv
module canrx_pack
    import canrx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap,
    input  logic                  in_ext,
    input  logic                  in_rtr,
    input  logic [3:0]            in_dlc,
    input  logic [ID_BITS-1:0]    in_id,
    input  logic [DATA_BITS-1:0]  in_data,
    input  logic [LEN_W-1:0]      idx,
    output logic [7:0]            out_byte,
    output logic [LEN_W-1:0]      out_len
);

    logic                 f_ext;
    logic                 f_rtr;
    logic [3:0]           f_dlc;
    logic [ID_BITS-1:0]   f_id;
    logic [DATA_BITS-1:0] f_data;
    logic [LEN_W-1:0]     id_span;
    logic [LEN_W-1:0]     j;
    logic [5:0]           bitpos;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_ext  <= 1'b0;
            f_rtr  <= 1'b0;
            f_dlc  <= 4'd0;
            f_id   <= '0;
            f_data <= '0;
        end else if (cap) begin
            f_ext  <= in_ext;
            f_rtr  <= in_rtr;
            f_dlc  <= (in_dlc > 4'd8) ? 4'd8 : in_dlc;
            f_id   <= in_id;
            f_data <= in_data;
        end
    end

    assign out_len = rec_len(f_ext, f_rtr, f_dlc);
    assign id_span = f_ext ? 4'd5 : 4'd3;
    assign j       = idx - id_span;
    assign bitpos  = {j[2:0], 3'b000};

    always_comb begin
        out_byte = f_data[bitpos +: 8];
        if (idx == 4'd0) begin
            out_byte = {f_ext, f_rtr, 2'b00, f_dlc};
        end else if (f_ext) begin
            unique case (idx)
                4'd1:    out_byte = f_id[28:21];
                4'd2:    out_byte = f_id[20:13];
                4'd3:    out_byte = f_id[12:5];
                4'd4:    out_byte = {f_id[4:0], 3'b000};
                default: out_byte = f_data[bitpos +: 8];
            endcase
        end else begin
            unique case (idx)
                4'd1:    out_byte = f_id[10:3];
                4'd2:    out_byte = {f_id[2:0], 5'b00000};
                default: out_byte = f_data[bitpos +: 8];
            endcase
        end
    end

    // R2/R3: any record spans 3 to 13 bytes
    assert_len_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_len >= 4'd3) && (out_len <= 4'd13));

endmodule

// File: rtl/canrx_mem.sv
module canrx_mem #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/canrx_ctrl.sv
module canrx_ctrl
    import canrx_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_reset,
    input  logic             st_valid,
    input  logic             rel,
    input  logic [LEN_W-1:0] new_len,
    input  logic [7:0]       head_byte,
    output logic             cap,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [LEN_W-1:0] byte_idx,
    output logic [AW-1:0]    rd_ptr,
    output logic             busy,
    output logic             rbs,
    output logic             ovr,
    output logic             irq_rx,
    output logic             irq_ovr
);

    rx_state_t        state, nxt;
    logic [AW-1:0]    wr_ptr;
    logic [CW-1:0]    byte_cnt;
    logic [CW-1:0]    msg_cnt;
    logic             hold_q;
    logic             leave;
    logic             fits;
    logic             last;
    logic             commit;
    logic             drop;
    logic             rel_ok;
    logic [LEN_W-1:0] rel_len;
    logic [CW:0]      need;

    assign need    = {1'b0, byte_cnt} + (CW+1)'(new_len);
    assign fits    = need <= (CW+1)'(DEPTH);
    assign last    = byte_idx == (new_len - 4'd1);
    assign leave   = hold_q && !hold_reset;
    assign rel_ok  = rel && (msg_cnt != '0);
    assign rel_len = hdr_len(head_byte);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (st_valid && !hold_reset) nxt = S_CHECK;
            S_CHECK: if (hold_reset || !fits)     nxt = S_IDLE;
                     else                         nxt = S_WRITE;
            S_WRITE: if (hold_reset || last)      nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        cap    = (state == S_IDLE) && st_valid && !hold_reset;
        wr_en  = (state == S_WRITE) && !hold_reset;
        commit = wr_en && last;
        drop   = (state == S_CHECK) && !hold_reset && !fits;
        busy   = state != S_IDLE;
    end

    assign wr_addr = wr_ptr + AW'(byte_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) byte_idx <= '0;
        else if (state == S_WRITE) byte_idx <= byte_idx + 4'd1;
        else byte_idx <= '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= 1'b0;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            byte_cnt <= '0;
            msg_cnt  <= '0;
            rbs      <= 1'b0;
            irq_rx   <= 1'b0;
            ovr      <= 1'b0;
            irq_ovr  <= 1'b0;
        end else begin
            hold_q <= hold_reset;
            if (drop) begin
                ovr     <= 1'b1;
                irq_ovr <= 1'b1;
            end
            if (leave) begin
                byte_cnt <= '0;
                msg_cnt  <= '0;
                rd_ptr   <= wr_ptr;
                rbs      <= 1'b0;
                irq_rx   <= 1'b0;
            end else begin
                byte_cnt <= byte_cnt + (commit ? CW'(new_len) : '0)
                                     - (rel_ok ? CW'(rel_len) : '0);
                msg_cnt  <= msg_cnt + (commit ? CW'(1) : '0)
                                    - (rel_ok ? CW'(1) : '0);
                if (commit) wr_ptr <= wr_ptr + AW'(new_len);
                if (rel_ok) rd_ptr <= rd_ptr + AW'(rel_len);
                if (commit) begin
                    rbs    <= 1'b1;
                    irq_rx <= 1'b1;
                end else if (rel_ok && msg_cnt == CW'(1)) begin
                    rbs    <= 1'b0;
                    irq_rx <= 1'b0;
                end
            end
        end
    end

    assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= CW'(DEPTH));

    assert_empty_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_cnt == '0) |-> !rbs);

    assert_commit_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> rbs && irq_rx);

    assert_empty_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && msg_cnt == '0 && !leave) |=> $stable(rd_ptr));

    assert_reset_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_reset |=> state == S_IDLE);

endmodule

// File: rtl/canrx_fifo.sv
module canrx_fifo
    import canrx_pkg::*;
#(
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned WIN_LEN = 13,
    localparam int unsigned AW     = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hold_reset,
    input  logic        st_valid,
    input  logic        st_ext,
    input  logic        st_rtr,
    input  logic [3:0]  st_dlc,
    input  logic [28:0] st_id,
    input  logic [63:0] st_data,
    input  logic        rel,
    input  logic [3:0]  win_addr,
    output logic [7:0]  win_data,
    output logic        rx_status,
    output logic        rx_overrun,
    output logic        rx_busy,
    output logic        irq_rx,
    output logic        irq_ovr
);

    // DEPTH must be a power of two: pointers wrap by plain truncation.
    logic             cap;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [LEN_W-1:0] byte_idx;
    logic [LEN_W-1:0] new_len;
    logic [7:0]       new_byte;
    logic [AW-1:0]    rd_ptr;
    logic [7:0]       head_byte;
    logic [7:0]       win_raw;

    canrx_pack u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .in_ext   (st_ext),
        .in_rtr   (st_rtr),
        .in_dlc   (st_dlc),
        .in_id    (st_id),
        .in_data  (st_data),
        .idx      (byte_idx),
        .out_byte (new_byte),
        .out_len  (new_len)
    );

    canrx_mem #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (new_byte),
        .raddr_a (rd_ptr + AW'(win_addr)),
        .rdata_a (win_raw),
        .raddr_b (rd_ptr),
        .rdata_b (head_byte)
    );

    canrx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_reset (hold_reset),
        .st_valid   (st_valid),
        .rel        (rel),
        .new_len    (new_len),
        .head_byte  (head_byte),
        .cap        (cap),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .byte_idx   (byte_idx),
        .rd_ptr     (rd_ptr),
        .busy       (rx_busy),
        .rbs        (rx_status),
        .ovr        (rx_overrun),
        .irq_rx     (irq_rx),
        .irq_ovr    (irq_ovr)
    );

    assign win_data = (32'(win_addr) < WIN_LEN) ? win_raw : 8'h00;

    assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> rx_overrun);

endmodule

// File: tb/canrx_fifo_tb.sv
module canrx_fifo_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold_reset = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ext = 1'b0;
    logic        st_rtr = 1'b0;
    logic [3:0]  st_dlc = 4'd0;
    logic [28:0] st_id = '0;
    logic [63:0] st_data = '0;
    logic        rel = 1'b0;
    logic [3:0]  win_addr = 4'd0;
    logic [7:0]  win_data;
    logic        rx_status, rx_overrun, rx_busy, irq_rx, irq_ovr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    canrx_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .hold_reset(hold_reset),
        .st_valid(st_valid), .st_ext(st_ext), .st_rtr(st_rtr),
        .st_dlc(st_dlc), .st_id(st_id), .st_data(st_data),
        .rel(rel), .win_addr(win_addr), .win_data(win_data),
        .rx_status(rx_status), .rx_overrun(rx_overrun), .rx_busy(rx_busy),
        .irq_rx(irq_rx), .irq_ovr(irq_ovr)
    );

    // {ext, rtr, dlc[3:0], id[28:0], data[63:0]}
    localparam logic [98:0] VEC [8] = '{
        {1'b1, 1'b0, 4'd8,  29'h1ABCDEF5, 64'h8877665544332211},
        {1'b0, 1'b0, 4'd8,  29'h000005A3, 64'h0F0E0D0C0B0A0908},
        {1'b1, 1'b1, 4'd4,  29'h00000123, 64'h0},
        {1'b0, 1'b1, 4'd5,  29'h000007FF, 64'h0},
        {1'b1, 1'b0, 4'd3,  29'h10000001, 64'h0000000000CCBBAA},
        {1'b0, 1'b0, 4'd0,  29'h00000001, 64'h0},
        {1'b1, 1'b0, 4'd8,  29'h0F0F0F0F, 64'hDEADBEEF01234567},
        {1'b0, 1'b0, 4'd12, 29'h000002AA, 64'h1122334455667788}
    };

    function automatic int blen(logic [98:0] v);
        int d;
        d = (v[96:93] > 4'd8) ? 8 : int'(v[96:93]);
        return (v[98] ? 5 : 3) + (v[97] ? 0 : d);
    endfunction

    function automatic logic [7:0] eb(logic [98:0] v, int k);
        logic [28:0] id;
        logic [3:0]  d;
        int j;
        id = v[92:64];
        d  = (v[96:93] > 4'd8) ? 4'd8 : v[96:93];
        if (k == 0) return {v[98], v[97], 2'b00, d};
        if (v[98]) begin
            if (k == 1) return id[28:21];
            if (k == 2) return id[20:13];
            if (k == 3) return id[12:5];
            if (k == 4) return {id[4:0], 3'b000};
            j = k - 5;
        end else begin
            if (k == 1) return id[10:3];
            if (k == 2) return {id[2:0], 5'b00000};
            j = k - 3;
        end
        return v[8*j +: 8];
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic strobe(logic [98:0] v);
        @(negedge clk);
        st_valid = 1'b1;
        st_ext = v[98]; st_rtr = v[97]; st_dlc = v[96:93];
        st_id = v[92:64]; st_data = v[63:0];
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100; i++) begin
            if (!rx_busy) break;
            @(negedge clk);
        end
    endtask

    task automatic store(logic [98:0] v);
        strobe(v);
        wait_idle();
    endtask

    task automatic release_one();
        @(negedge clk);
        rel = 1'b1;
        @(negedge clk);
        rel = 1'b0;
    endtask

    task automatic win(int k, output logic [7:0] b);
        win_addr = 4'(k);
        #1;
        b = win_data;
    endtask

    function automatic logic [98:0] mk(logic ext, logic rtr, logic [3:0] dlc, logic [28:0] id);
        return {ext, rtr, dlc, id, 64'h0706050403020100};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "rx_status", int'(rx_status), 0);
        chk("R11", "rx_overrun", int'(rx_overrun), 0);
        chk("R11", "rx_busy", int'(rx_busy), 0);
        chk("R11", "irq_rx", int'(irq_rx), 0);
        chk("R11", "irq_ovr", int'(irq_ovr), 0);
        win(0, b); chk("R11", "window byte", int'(b), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R6 R7 R8, start pointer wraps past 64
        foreach (VEC[i]) begin
            store(VEC[i]);
            chk("R6", "rx_status after store", int'(rx_status), 1);
            chk("R6", "irq_rx after store", int'(irq_rx), 1);
            for (int k = 0; k < blen(VEC[i]); k++) begin
                win(k, b);
                chk(k == 0 ? "R1" : (VEC[i][98] ? "R2" : "R3"), "record byte", int'(b), int'(eb(VEC[i], k)));
            end
            release_one();
            chk("R8", "rx_status after last release", int'(rx_status), 0);
            chk("R8", "irq_rx after last release", int'(irq_rx), 0);
        end

        // R8: release with nothing held is ignored
        release_one();
        store(mk(1'b0, 1'b0, 4'd2, 29'h155));
        win(0, b); chk("R8", "header after empty release", int'(b), 8'h02);
        win(1, b); chk("R8", "id byte after empty release", int'(b), 8'h2A);
        release_one();

        // R10: busy and strobe while busy
        strobe(mk(1'b0, 1'b0, 4'd2, 29'h100));
        chk("R10", "rx_busy after strobe", int'(rx_busy), 1);
        st_valid = 1'b1; st_dlc = 4'd5;
        @(negedge clk); st_valid = 1'b0;
        wait_idle();
        chk("R10", "rx_busy after store", int'(rx_busy), 0);
        win(0, b); chk("R10", "header of first frame", int'(b), 8'h02);
        release_one();
        chk("R10", "second strobe ignored", int'(rx_status), 0);

        // R5: overrun drop and exact fill; R7 ordering across records
        for (int i = 0; i < 4; i++) store(mk(1'b1, 1'b0, 4'd8, 29'(i + 1)));
        chk("R5", "overrun before drop", int'(rx_overrun), 0);
        store(mk(1'b1, 1'b0, 4'd8, 29'h1F));
        chk("R5", "rx_overrun on drop", int'(rx_overrun), 1);
        chk("R5", "irq_ovr on drop", int'(irq_ovr), 1);
        store(mk(1'b1, 1'b0, 4'd7, 29'h15));
        for (int i = 0; i < 4; i++) begin
            win(4, b); chk("R7", "id low byte of held record", int'(b), int'({5'(i + 1), 3'b000}));
            release_one();
        end
        chk("R5", "exact-fill record held", int'(rx_status), 1);
        win(0, b); chk("R5", "exact-fill header", int'(b), 8'h87);
        win(4, b); chk("R5", "exact-fill id, dropped frame absent", int'(b), 8'hA8);
        win(13, b); chk("R4", "offset 13 reads zero", int'(b), 0);
        release_one();
        chk("R8", "empty after releases", int'(rx_status), 0);

        // R9: hold in reset
        store(mk(1'b0, 1'b0, 4'd1, 29'h7A));
        @(negedge clk); hold_reset = 1'b1;
        strobe(mk(1'b1, 1'b0, 4'd8, 29'h3));
        chk("R9", "rx_busy during hold", int'(rx_busy), 0);
        @(negedge clk); hold_reset = 1'b0;
        @(negedge clk);
        chk("R9", "rx_status after leaving", int'(rx_status), 0);
        chk("R9", "irq_rx after leaving", int'(irq_rx), 0);
        release_one();
        store(mk(1'b0, 1'b0, 4'd0, 29'h03C));
        win(0, b); chk("R9", "header after realign", int'(b), 8'h00);
        win(1, b); chk("R9", "id high after realign", int'(b), 8'h07);
        win(2, b); chk("R9", "id low after realign", int'(b), 8'h80);
        chk("R5", "irq_ovr sticky", int'(irq_ovr), 1);
        release_one();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule